// File: doc/BRIEF.md
# Lock-Guarded System Control Register Bank

This block is a small bank of memory-mapped control and status words for a board-level system controller. It sits on a plain 32-bit register bus that is addressed by word index, so word index N is byte offset 4*N. A read is captured on a clock edge and its data appears on `rdata` for the following cycle. A write takes effect on the edge where it is presented. The bank holds the following:

- a fixed identity word, whose bits 27:16 carry the board ID;
- an LED output word;
- two flag words, each with separate set and clear addresses;
- a card status word fed from two level inputs;
- a reset-control word that software can change only after it has loaded a magic key into a lock word.

The board ID is taken from the identity word, which is a parameter. The board ID sets two things: the bit of the reset-control word that triggers the reset request, and the status bit that carries write-protect. When an accepted reset-control write has its trigger bit set, the block raises `sys_rst_req`, a registered pulse on the bus clock. Offsets that are reserved placeholders read as zero and ignore writes. Any access beyond the last mapped word returns zero and pulses `bus_err` for one cycle.

Top module: `sysctl_regbank`

## Requirements
- R1: Word 0 (byte 0x00) always reads the `ID_WORD` parameter, and a write to it changes nothing.
- R2: Word 2 (byte 0x08) is a 32-bit LED register: it reads back the last value written and drives no other state.
- R3: A write to the lock word (byte 0x20) of exactly 0xA05F in bits 15:0 stores 0xA05F. Any other value is stored as its bits 15:0 ANDed with 0x7FFF. A read returns the stored 16 bits, zero-extended.
- R4: A write to the reset-control word (byte 0x40) is accepted only while the lock word holds 0xA05F; otherwise it is ignored. On variants that implement the word, it reads back the last accepted value.
- R5: An accepted reset-control write raises `sys_rst_req` for the one cycle after the write edge, if its trigger bit is set. The trigger bit is bit 8 for board ID 0x100 and bit 2 for board IDs 0x178 and 0x182. A write without the trigger bit raises no request.
- R6: On every other board ID, the reset-control word reads as zero, ignores writes and never raises `sys_rst_req`.
- R7: A write to byte 0x30 ORs the data into the flag word. A write to byte 0x34 clears the flag bits that are 1 in the data. A read of byte 0x30 returns the flag word.
- R8: The persistent flag word behaves the same way at byte 0x38 (set, and read) and byte 0x3C (clear), and it keeps its value through reset.
- R9: Reset (`rst_n` low at a clock edge) clears the LED, lock, flag and reset-control words to zero and holds `sys_rst_req` and `bus_err` low.
- R10: Byte 0x48 reads `card_present` in bit 0. It reads `write_prot` in bit 2 for board IDs 0x100 and 0x140, and in bit 1 for all other board IDs. All other bits read zero.
- R11: Byte 0x44 always reads 1. All other words up to byte 0x48 that are not named above read zero, ignore writes and raise no error; this includes the oscillator words at bytes 0x0C to 0x1C and the clear aliases.
- R12: A read or write of a word index above 18 (past byte 0x48) changes no state. `bus_err` goes high for the one cycle after that access, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| reg_idx | input | IDX_W | Word index (byte offset divided by 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped word |
| card_present | input | 1 | Card-present level input |
| write_prot | input | 1 | Card write-protect level input |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Three instances run side by side on a shared bus, with board IDs 0x100, 0x182 and 0x140. One reset-control write with only bit 2 set therefore shows all three trigger rules at once: the 0x182 instance requests a reset, the 0x100 instance stores the value silently, and the 0x140 instance drops it. The lock is exercised with the key, with a near-miss value whose bit 15 has to be masked off, and with a relock; each case shows whether the reset-control word is writable at that moment. The flag words receive overlapping set and clear patterns that separate the OR behaviour from the AND-NOT behaviour. A mid-test reset separates the volatile flag word from the persistent one. The card inputs are driven with each input high on its own, which exposes where each variant places the write-protect bit.

// File: rtl/sysctl_regbank_pkg.sv
// Package: shared constants, word indices and board-variant decoding for
// the system control register bank. Assumes word-indexed addressing.
package sysctl_regbank_pkg;

    localparam int unsigned DATA_W = 32;

    // Magic key that opens the reset-control word
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

    // Word indices (byte offset / 4)
    localparam int unsigned IDX_ID       = 0;
    localparam int unsigned IDX_LED      = 2;
    localparam int unsigned IDX_LOCK     = 8;
    localparam int unsigned IDX_FLAG_SET = 12;
    localparam int unsigned IDX_FLAG_CLR = 13;
    localparam int unsigned IDX_NV_SET   = 14;
    localparam int unsigned IDX_NV_CLR   = 15;
    localparam int unsigned IDX_RSTCTL   = 16;
    localparam int unsigned IDX_PCI      = 17;
    localparam int unsigned IDX_CARD     = 18;
    localparam int unsigned IDX_LAST     = 18;

    typedef enum logic [1:0] {
        VAR_EARLY_MUX,    // ID 0x100: reset bit 8, write-protect bit 2
        VAR_EARLY_NOMUX,  // ID 0x140: no reset word, write-protect bit 2
        VAR_LATE_RST,     // ID 0x178/0x182: reset bit 2, write-protect bit 1
        VAR_OTHER         // anything else: no reset word, write-protect bit 1
    } variant_e;

    // Map an identity word to its board variant (board ID in bits 27:16)
    function automatic variant_e variant_of(input logic [31:0] id_word);
        case (id_word[27:16])
            12'h100:         return VAR_EARLY_MUX;
            12'h140:         return VAR_EARLY_NOMUX;
            12'h178, 12'h182: return VAR_LATE_RST;
            default:         return VAR_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_lock.sv
// Module: lock word. Stores the unlock key verbatim and any other value
// with bit 15 forced low, so only the exact key reads as unlocked.
// Assumes `we` is an already decoded write strobe for the lock index.
module sysctl_lock
    import sysctl_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] lock_q,
    output logic        unlocked
);

    // Capture the key as-is, mask everything else
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '0;
        else if (we)
            lock_q <= (wdata == UNLOCK_KEY) ? wdata : (wdata & 16'h7FFF);
    end

    // Unlocked only while the key itself is held
    always_comb unlocked = (lock_q == UNLOCK_KEY);

    // R3: a non-key write always leaves the word locked with bit 15 clear
    p_lock_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata != UNLOCK_KEY) |=> (!unlocked && !lock_q[15]));

endmodule

// File: rtl/sysctl_setclr.sv
// Module: set/clear flag word. A set strobe ORs data in, a clear strobe
// removes the bits set in data. RESETTABLE picks whether reset clears it.
// Assumes set and clear strobes are never high together (distinct indices).
module sysctl_setclr #(
    parameter int unsigned W          = 32,
    parameter bit          RESETTABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    // Next value from the set/clear strobes
    always_comb begin
        q_next = q;
        if (set_we)      q_next = q | wdata;
        else if (clr_we) q_next = q & ~wdata;
    end

    generate
        if (RESETTABLE) begin : g_rst
            // Volatile word, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= q_next;
            end
        end else begin : g_keep
            // Persistent word, untouched by reset
            always_ff @(posedge clk) begin
                q <= q_next;
            end
        end
    endgenerate

    // R7/R8: after a set, every data bit is present
    p_set_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(wdata)) == $past(wdata)));
    // R7/R8: after a clear, no data bit remains
    p_clr_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));

endmodule

// File: rtl/sysctl_rstctl.sv
// Module: reset-control word with lock gating. Stores an accepted write
// and issues a registered reset request when the trigger bit is set.
// TRIG_EN = 0 makes the word read as zero and never request a reset.
module sysctl_rstctl #(
    parameter int unsigned W        = 32,
    parameter bit          TRIG_EN  = 1'b1,
    parameter int unsigned TRIG_BIT = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         unlocked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level_q,
    output logic         req
);

    logic [W-1:0] level_r;
    logic         accept;

    // A write counts only on an implemented word while unlocked
    always_comb accept = we && unlocked && TRIG_EN;

    // Hold the last accepted reset-control value
    always_ff @(posedge clk) begin
        if (!rst_n)      level_r <= '0;
        else if (accept) level_r <= wdata;
    end

    // Register the reset request from the trigger bit
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= accept && wdata[TRIG_BIT];
    end

    // Unimplemented variants read as zero
    always_comb level_q = TRIG_EN ? level_r : '0;

    // R4: a request implies an unlocked write with the trigger bit one cycle earlier
    p_req_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(we && unlocked && wdata[TRIG_BIT]));
    // R4: without an unlocked write the stored value holds
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(we && unlocked)) |=> $stable(level_q));
    // R6: an unimplemented word never requests
    p_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !TRIG_EN |-> (!req && level_q == '0));

endmodule

// File: rtl/sysctl_regbank.sv
// Module: top of the system control register bank. Decodes word indices,
// hosts the LED word, card status, placeholders and read-back mux, and
// instantiates the lock, flag and reset-control pieces. Assumes a
// single-cycle bus: strobes are sampled at the rising edge, read data and
// the error pulse are registered and valid in the following cycle.
module sysctl_regbank
    import sysctl_regbank_pkg::*;
#(
    parameter logic [31:0] ID_WORD = 32'h4100_0A5C,
    parameter int unsigned IDX_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             bus_err,
    input  logic             card_present,
    input  logic             write_prot,
    output logic             sys_rst_req
);

    localparam variant_e    VARIANT  = variant_of(ID_WORD);
    localparam bit          RST_EN   = (VARIANT == VAR_EARLY_MUX) || (VARIANT == VAR_LATE_RST);
    localparam int unsigned RST_BIT  = (VARIANT == VAR_EARLY_MUX) ? 8 : 2;
    localparam int unsigned WP_BIT   = ((VARIANT == VAR_EARLY_MUX) ||
                                        (VARIANT == VAR_EARLY_NOMUX)) ? 2 : 1;

    logic              hit_led, hit_lock, hit_fset, hit_fclr;
    logic              hit_nset, hit_nclr, hit_rst, unmapped;
    logic [DATA_W-1:0] led_q, flags_q, nvflags_q, rstlvl_q;
    logic [15:0]       lock_q;
    logic              unlocked;
    logic [DATA_W-1:0] card_word;
    logic [DATA_W-1:0] rd_mux;

    // Index decode for the write side and the error check
    always_comb begin
        hit_led  = (reg_idx == IDX_W'(IDX_LED));
        hit_lock = (reg_idx == IDX_W'(IDX_LOCK));
        hit_fset = (reg_idx == IDX_W'(IDX_FLAG_SET));
        hit_fclr = (reg_idx == IDX_W'(IDX_FLAG_CLR));
        hit_nset = (reg_idx == IDX_W'(IDX_NV_SET));
        hit_nclr = (reg_idx == IDX_W'(IDX_NV_CLR));
        hit_rst  = (reg_idx == IDX_W'(IDX_RSTCTL));
        unmapped = (reg_idx >  IDX_W'(IDX_LAST));
    end

    // LED word
    always_ff @(posedge clk) begin
        if (!rst_n)                 led_q <= '0;
        else if (wr_en && hit_led)  led_q <= wdata;
    end

    sysctl_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en && hit_lock),
        .wdata    (wdata[15:0]),
        .lock_q   (lock_q),
        .unlocked (unlocked)
    );

    sysctl_setclr #(.W(DATA_W), .RESETTABLE(1'b1)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_en && hit_fset),
        .clr_we (wr_en && hit_fclr),
        .wdata  (wdata),
        .q      (flags_q)
    );

    sysctl_setclr #(.W(DATA_W), .RESETTABLE(1'b0)) u_nvflags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_en && hit_nset),
        .clr_we (wr_en && hit_nclr),
        .wdata  (wdata),
        .q      (nvflags_q)
    );

    sysctl_rstctl #(.W(DATA_W), .TRIG_EN(RST_EN), .TRIG_BIT(RST_BIT)) u_rstctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en && hit_rst),
        .unlocked (unlocked),
        .wdata    (wdata),
        .level_q  (rstlvl_q),
        .req      (sys_rst_req)
    );

    // Card status word: presence in bit 0, write-protect at the variant's bit
    always_comb begin
        card_word         = '0;
        card_word[0]      = card_present;
        card_word[WP_BIT] = write_prot;
    end

    // Read-back mux; placeholders and unmapped words give zero
    always_comb begin
        rd_mux = '0;
        case (int'(reg_idx))
            IDX_ID:       rd_mux = ID_WORD;
            IDX_LED:      rd_mux = led_q;
            IDX_LOCK:     rd_mux = {16'h0, lock_q};
            IDX_FLAG_SET: rd_mux = flags_q;
            IDX_NV_SET:   rd_mux = nvflags_q;
            IDX_RSTCTL:   rd_mux = rstlvl_q;
            IDX_PCI:      rd_mux = 32'h1;
            IDX_CARD:     rd_mux = card_word;
            default:      rd_mux = '0;
        endcase
    end

    // Register read data and the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            bus_err <= 1'b0;
        end else begin
            if (rd_en) rdata <= rd_mux;
            bus_err <= (rd_en || wr_en) && unmapped;
        end
    end

    // R12: an access past the map raises the error in the next cycle
    p_err_raise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && reg_idx > IDX_W'(IDX_LAST)) |=> bus_err);
    // R12: an unmapped read returns zero
    p_err_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx > IDX_W'(IDX_LAST)) |=> (rdata == '0));
    // R11: the fixed word always reads 1
    p_pci_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == IDX_W'(IDX_PCI)) |=> (rdata == 32'h1));
    // R10: card-present lands in bit 0 of the status read
    p_card_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == IDX_W'(IDX_CARD)) |=> (rdata[0] == $past(card_present)));
    // R1: identity read returns the parameter
    p_id_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == IDX_W'(IDX_ID)) |=> (rdata == ID_WORD));

endmodule

// File: tb/sysctl_regbank_tb.sv
`timescale 1ns/1ps
// Directed bench: three variants (0x100, 0x182, 0x140) on one shared bus.
module sysctl_regbank_tb;

    localparam int IDX_W = 10;
    localparam logic [31:0] ID_A = 32'h4100_0A5C;  // board 0x100
    localparam logic [31:0] ID_B = 32'h4182_0A5C;  // board 0x182
    localparam logic [31:0] ID_C = 32'h4140_0A5C;  // board 0x140

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [31:0]      wdata = '0;
    logic             card_present = 1'b0, write_prot = 1'b0;
    logic [31:0]      rdata_a, rdata_b, rdata_c;
    logic             err_a, err_b, err_c;
    logic             req_a, req_b, req_c;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [31:0] qa, qb, qc;
    logic        ea;

    always #2.5 clk = ~clk;

    sysctl_regbank #(.ID_WORD(ID_A), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
        .wdata(wdata), .rdata(rdata_a), .bus_err(err_a),
        .card_present(card_present), .write_prot(write_prot), .sys_rst_req(req_a));
    sysctl_regbank #(.ID_WORD(ID_B), .IDX_W(IDX_W)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
        .wdata(wdata), .rdata(rdata_b), .bus_err(err_b),
        .card_present(card_present), .write_prot(write_prot), .sys_rst_req(req_b));
    sysctl_regbank #(.ID_WORD(ID_C), .IDX_W(IDX_W)) u_dut_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
        .wdata(wdata), .rdata(rdata_c), .bus_err(err_c),
        .card_present(card_present), .write_prot(write_prot), .sys_rst_req(req_c));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Write: returns at the falling edge after the capturing edge
    task automatic bus_wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = IDX_W'(idx); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read: data of all three instances sampled one cycle after the strobe
    task automatic bus_rd(input int idx);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = IDX_W'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        qa = rdata_a; qb = rdata_b; qc = rdata_c; ea = err_a;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R9 req low in reset", {29'b0, req_a, req_b, req_c}, 32'h0);
        bus_rd(2);  check("R9 LED after reset", qa, 32'h0);
        bus_rd(8);  check("R9 lock after reset", qa, 32'h0);
        bus_rd(12); check("R9 flags after reset", qa, 32'h0);
        bus_rd(16); check("R9 reset word after reset", qa, 32'h0);
        check("R9 err low", {31'b0, ea}, 32'h0);
    endtask

    task automatic t_identity();
        bus_rd(0);
        check("R1 id variant A", qa, ID_A);
        check("R1 id variant B", qb, ID_B);
        check("R1 id variant C", qc, ID_C);
        bus_wr(0, 32'hFFFF_FFFF);
        bus_rd(0);
        check("R1 id after write", qa, ID_A);
    endtask

    task automatic t_led();
        bus_wr(2, 32'h0000_02A5);
        bus_rd(2); check("R2 LED readback", qa, 32'h0000_02A5);
        bus_wr(2, 32'hDEAD_0001);
        bus_rd(2); check("R2 LED second value", qa, 32'hDEAD_0001);
    endtask

    task automatic t_lock_and_reset();
        // locked: reset word write dropped
        bus_wr(16, 32'h0000_0104);
        check("R4 no req while locked A", {31'b0, req_a}, 32'h0);
        check("R4 no req while locked B", {31'b0, req_b}, 32'h0);
        bus_rd(16); check("R4 locked write ignored", qa, 32'h0);
        // near-miss value masked
        bus_wr(8, 32'h0000_A05E);
        bus_rd(8);  check("R3 masked lock", qa, 32'h0000_205E);
        bus_wr(16, 32'h0000_0004);
        bus_rd(16); check("R4 near-miss still locked", qb, 32'h0);
        // key opens
        bus_wr(8, 32'h0000_A05F);
        bus_rd(8);  check("R3 key stored", qa, 32'h0000_A05F);
        bus_wr(16, 32'h0000_0004);
        check("R5 bit2 fires on 0x182", {31'b0, req_b}, 32'h1);
        check("R5 bit2 silent on 0x100", {31'b0, req_a}, 32'h0);
        check("R6 never fires on 0x140", {31'b0, req_c}, 32'h0);
        @(negedge clk);
        check("R5 pulse one cycle", {31'b0, req_b}, 32'h0);
        bus_rd(16);
        check("R4 stored on 0x100", qa, 32'h0000_0004);
        check("R4 stored on 0x182", qb, 32'h0000_0004);
        check("R6 reads zero on 0x140", qc, 32'h0);
        bus_wr(16, 32'h0000_0100);
        check("R5 bit8 fires on 0x100", {31'b0, req_a}, 32'h1);
        check("R5 bit8 silent on 0x182", {31'b0, req_b}, 32'h0);
        @(negedge clk);
        check("R5 pulse ends on 0x100", {31'b0, req_a}, 32'h0);
        // relock with bit 15 set in data
        bus_wr(8, 32'h0000_FFFF);
        bus_rd(8);  check("R3 relock masked", qa, 32'h0000_7FFF);
        bus_wr(16, 32'h0000_0104);
        check("R4 relocked no req", {30'b0, req_a, req_b}, 32'h0);
        bus_rd(16); check("R4 relocked value kept", qa, 32'h0000_0100);
    endtask

    task automatic t_flags();
        bus_wr(12, 32'h0000_000F);
        bus_wr(12, 32'h0000_00F0);
        bus_rd(12); check("R7 set ORs", qa, 32'h0000_00FF);
        bus_wr(13, 32'h0000_003C);
        bus_rd(12); check("R7 clear removes bits", qa, 32'h0000_00C3);
        bus_wr(15, 32'hFFFF_FFFF);
        bus_wr(14, 32'h8000_0081);
        bus_wr(15, 32'h0000_0001);
        bus_rd(14); check("R8 nv set/clear", qa, 32'h8000_0080);
    endtask

    task automatic t_reset_keeps_nv();
        do_reset();
        bus_rd(14); check("R8 nv survives reset", qa, 32'h8000_0080);
        bus_rd(12); check("R9 flags cleared", qa, 32'h0);
        bus_rd(2);  check("R9 LED cleared", qa, 32'h0);
        bus_rd(8);  check("R9 lock cleared", qa, 32'h0);
        bus_rd(16); check("R9 reset word cleared", qa, 32'h0);
    endtask

    task automatic t_card();
        card_present = 1'b1; write_prot = 1'b0;
        bus_rd(18);
        check("R10 present only A", qa, 32'h1);
        check("R10 present only B", qb, 32'h1);
        card_present = 1'b0; write_prot = 1'b1;
        bus_rd(18);
        check("R10 wp bit2 on 0x100", qa, 32'h4);
        check("R10 wp bit1 on 0x182", qb, 32'h2);
        check("R10 wp bit2 on 0x140", qc, 32'h4);
        write_prot = 1'b0;
    endtask

    task automatic t_placeholders();
        bus_rd(17); check("R11 fixed word is 1", qa, 32'h1);
        bus_wr(3, 32'hFFFF_FFFF);
        check("R11 placeholder write no err", {31'b0, err_a}, 32'h0);
        bus_rd(3); check("R11 oscillator reads zero", qa, 32'h0);
        bus_rd(7); check("R11 last oscillator zero", qa, 32'h0);
        bus_rd(13); check("R11 clear alias reads zero", qa, 32'h0);
        check("R11 no err on mapped", {31'b0, ea}, 32'h0);
    endtask

    task automatic t_unmapped();
        bus_wr(2, 32'h0000_1234);
        bus_rd(19);
        check("R12 unmapped reads zero", qa, 32'h0);
        check("R12 err raised on read", {31'b0, ea}, 32'h1);
        @(negedge clk);
        check("R12 err one cycle", {31'b0, err_a}, 32'h0);
        bus_wr(40, 32'hFFFF_FFFF);
        check("R12 err raised on write", {31'b0, err_a}, 32'h1);
        bus_rd(2); check("R12 unmapped write changed nothing", qa, 32'h0000_1234);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_identity();
        t_led();
        t_lock_and_reset();
        t_flags();
        t_reset_keeps_nv();
        t_card();
        t_placeholders();
        t_unmapped();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule